// File: doc/BRIEF.md
# Prioritized Interrupt Request Arbiter

This block gathers interrupt requests from a fixed set of sources and picks the single request to present to the processor. Sources fall into two classes. Eight exception-class sources sit at a fixed level 8 that no mask can hold back. Index 0 of this class is the non-maskable interrupt, which outranks everything. All other sources are ordinary: each takes a programmable 3-bit level, written through a small write port.

Every request pulse is latched as a pending bit. While no request is outstanding, the block chooses the best eligible pending source. It then raises a request strobe carrying a vector number that belongs to that source alone, so the handler never has to search for the cause. The strobe, vector and level hold until the processor acknowledges. The acknowledge clears the pending bit of the granted source.

A two-bit mode input chooses between two acceptance rules. In the simple mode, ordinary sources are gated only by one global enable. In the priority mode, they are gated by a 3-bit processor mask level.

Top module: `intc_arbiter`

## Requirements
- R1: After reset, irq is low, no source is pending, and every ordinary source's level is 0.
- R2: A one-cycle high on exc_req[k] or src_req[j] sets that source's pending bit at the next rising edge. If the source is eligible and no request is outstanding, irq rises at the edge after that.
- R3: Exception source k (0..7) reports vector VEC_BASE+k. Ordinary source j reports vector VEC_BASE+8+j. irq_lvl reports 8 for exception sources and the programmed level for ordinary ones.
- R4: Pending exception sources are always accepted, whatever the mode, the mask or glb_en. They beat every ordinary source, and the lowest exception index wins, so the non-maskable interrupt (index 0) ranks highest.
- R5: Among eligible ordinary sources, the highest level wins. On a tie, the lowest index (lowest vector) wins.
- R6: Priority mode is ictl_mode = 2'b10. In this mode an ordinary source is eligible only if its level is strictly greater than cpu_mask, so a source at level 0 is never eligible.
- R7: Every other ictl_mode value selects simple mode. In simple mode, ordinary sources are eligible exactly when glb_en is 1, whatever their level or cpu_mask.
- R8: While irq is high and ack is low, irq, irq_vec and irq_lvl stay unchanged, even when a higher-ranked request arrives.
- R9: An ack while irq is high clears the granted source's pending bit at that edge, and irq is low for the next cycle. An ack while irq is low changes nothing.
- R10: With cfg_we high, cfg_lvl is written to ordinary source cfg_sel at the rising edge. A cfg_sel value of N_SRC or above writes nothing.
- R11: A request that is not eligible stays pending. It is presented as soon as a mode, mask or enable change makes it eligible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | 8 | Exception-class request pulses, index 0 is the non-maskable interrupt |
| src_req | input | N_SRC | Ordinary request pulses |
| cfg_we | input | 1 | Level write enable |
| cfg_sel | input | SEL_W | Ordinary source selected for the write |
| cfg_lvl | input | 3 | Level value to write |
| ictl_mode | input | 2 | Control mode, 2'b10 for priority mode, any other value for simple mode |
| glb_en | input | 1 | Global enable for ordinary sources in simple mode |
| cpu_mask | input | 3 | Processor mask level used in priority mode |
| ack | input | 1 | Acknowledge pulse for the presented request |
| irq | output | 1 | Request strobe to the processor |
| irq_vec | output | VEC_W | Vector number of the presented source |
| irq_lvl | output | 4 | Level of the presented source (8 for exception class) |

## Verification
A wrong pending bit shows up in one of two ways. A source is presented that was never requested, or a taken source is presented again once it has been acknowledged. In both cases the fault appears at irq_vec one cycle after the acknowledge that should have cleared it. A stored level written to the wrong source, or a wrong comparison against the mask, shows in the vector order of simultaneous requests, or as a strobe that appears or stays away when the mask is changed. The tests therefore drain every queue one acknowledge at a time and check the vector after each acknowledge, two edges after each request pulse.

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
  parameter int N_SRC    = 16,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 32,
  localparam int SEL_W   = $clog2(N_SRC) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       exc_req,
  input  logic [N_SRC-1:0] src_req,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic [2:0]       cfg_lvl,
  input  logic [1:0]       ictl_mode,
  input  logic             glb_en,
  input  logic [2:0]       cpu_mask,
  input  logic             ack,
  output logic             irq,
  output logic [VEC_W-1:0] irq_vec,
  output logic [3:0]       irq_lvl
);
  localparam int N_EXC = 8;
  localparam int N_ALL = N_EXC + N_SRC;
  localparam int IDX_W = $clog2(N_ALL);

  logic [2:0]       lvl_q [N_SRC];
  logic [N_ALL-1:0] pend_q;
  logic             irq_q;
  logic [IDX_W-1:0] idx_q;
  logic [3:0]       lvl_out_q;

  logic [N_ALL-1:0] req_all;
  logic [N_ALL-1:0] elig;
  logic [3:0]       eff [N_ALL];
  logic [N_ALL-1:0] clr;
  logic             found;
  logic [IDX_W-1:0] win_idx;
  logic [3:0]       win_lvl;

  wire prio_mode = (ictl_mode == 2'b10);

  assign req_all = {src_req, exc_req};
  assign clr     = (irq_q && ack) ? (N_ALL'(1) << idx_q) : '0;

  for (genvar g = 0; g < N_ALL; g++) begin : g_elig
    if (g < N_EXC) begin : g_exc
      assign eff[g]  = 4'd8;
      assign elig[g] = pend_q[g];
    end else begin : g_ord
      assign eff[g]  = {1'b0, lvl_q[g-N_EXC]};
      assign elig[g] = pend_q[g] &
                       (prio_mode ? (lvl_q[g-N_EXC] > cpu_mask) : glb_en);
    end
  end

  always_comb begin
    found   = 1'b0;
    win_idx = '0;
    win_lvl = '0;
    for (int i = 0; i < N_ALL; i++) begin
      if (elig[i] && (!found || eff[i] > win_lvl)) begin
        found   = 1'b1;
        win_idx = i[IDX_W-1:0];
        win_lvl = eff[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      for (int j = 0; j < N_SRC; j++) lvl_q[j] <= '0;
    end else begin
      pend_q <= (pend_q & ~clr) | req_all;
      for (int j = 0; j < N_SRC; j++)
        if (cfg_we && cfg_sel == SEL_W'(j)) lvl_q[j] <= cfg_lvl;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q     <= 1'b0;
      idx_q     <= '0;
      lvl_out_q <= '0;
    end else if (irq_q) begin
      if (ack) irq_q <= 1'b0;
    end else if (found) begin
      irq_q     <= 1'b1;
      idx_q     <= win_idx;
      lvl_out_q <= win_lvl;
    end
  end

  assign irq     = irq_q;
  assign irq_vec = VEC_W'(VEC_BASE) + VEC_W'(idx_q);
  assign irq_lvl = lvl_out_q;

  a_r8_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q && !ack |=> irq_q && $stable(idx_q) && $stable(lvl_out_q));

  a_r9_ack_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q && ack |=> !irq_q);

  a_r9_ack_clears_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q && ack && !req_all[idx_q] |=> !pend_q[$past(idx_q)]);

  a_r9_idle_ack_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_q && ack |=> pend_q == ($past(pend_q) | $past(req_all)));

  a_r4_exception_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) && lvl_out_q != 4'd8 |-> $past(pend_q[N_EXC-1:0]) == '0);

  a_r6_above_mask: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) && lvl_out_q != 4'd8 && $past(prio_mode)
      |-> lvl_out_q > {1'b0, $past(cpu_mask)});

  a_r3_level_range: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (lvl_out_q == 4'd8) == (idx_q < IDX_W'(N_EXC)));
endmodule

// File: tb/sim_intc_arbiter.sv
`timescale 1ns/1ps
module sim_intc_arbiter;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  exc_req = 0;
  logic [15:0] src_req = 0;
  logic        cfg_we = 0;
  logic [4:0]  cfg_sel = 0;
  logic [2:0]  cfg_lvl = 0;
  logic [1:0]  ictl_mode = 0;
  logic        glb_en = 0;
  logic [2:0]  cpu_mask = 0;
  logic        ack = 0;
  logic        irq;
  logic [7:0]  irq_vec;
  logic [3:0]  irq_lvl;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  intc_arbiter u0 (.clk, .rst_n, .exc_req, .src_req, .cfg_we, .cfg_sel,
    .cfg_lvl, .ictl_mode, .glb_en, .cpu_mask, .ack, .irq, .irq_vec, .irq_lvl);

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(input string tag, input bit e_irq,
                            input int e_vec, input int e_lvl);
    n_chk++;
    if (irq !== e_irq || (e_irq && (irq_vec !== 8'(e_vec) || irq_lvl !== 4'(e_lvl)))) begin
      n_bad++;
      $display("FAIL %s: irq=%0d vec=%0d lvl=%0d expected irq=%0d vec=%0d lvl=%0d",
               tag, irq, irq_vec, irq_lvl, e_irq, e_vec, e_lvl);
    end
  endtask

  task automatic pulse(input logic [7:0] e, input logic [15:0] s);
    @(negedge clk); exc_req = e; src_req = s;
    @(negedge clk); exc_req = 0; src_req = 0;
  endtask

  task automatic ack_it();
    @(negedge clk); ack = 1;
    @(negedge clk); ack = 0;
  endtask

  task automatic wr_lvl(input int sel, input int val);
    @(negedge clk); cfg_we = 1; cfg_sel = 5'(sel); cfg_lvl = 3'(val);
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic t_reset();
    step(1);
    expect_out("R1 idle after reset", 0, 0, 0);
    ictl_mode = 2'b10; cpu_mask = 0;
    pulse(0, 16'h0010);
    step(2);
    expect_out("R1/R6 reset level 0 blocked in priority mode", 0, 0, 0);
    ictl_mode = 2'b00; glb_en = 1;
    step(1);
    expect_out("R7/R11 level 0 accepted in simple mode", 1, 44, 0);
    ack_it();
  endtask

  task automatic t_setup();
    wr_lvl(0, 1); wr_lvl(1, 2); wr_lvl(2, 5); wr_lvl(5, 5); wr_lvl(7, 3);
    wr_lvl(16, 7);
  endtask

  task automatic t_basic();
    ictl_mode = 2'b00; glb_en = 1;
    pulse(0, 16'h0080);
    expect_out("R2 not yet presented one edge after pulse", 0, 0, 0);
    step(1);
    expect_out("R2/R3 ordinary vector", 1, 47, 3);
    ack_it();
    expect_out("R9 irq low after ack", 0, 0, 0);
    step(2);
    expect_out("R9 acked source not re-presented", 0, 0, 0);
  endtask

  task automatic t_tie();
    pulse(0, 16'h00A4);
    step(1); expect_out("R5 tie lowest index", 1, 42, 5);
    ack_it(); step(1); expect_out("R5 second at same level", 1, 45, 5);
    ack_it(); step(1); expect_out("R5 lower level last", 1, 47, 3);
    ack_it();
  endtask

  task automatic t_exc();
    ictl_mode = 2'b10; cpu_mask = 7;
    pulse(8'h09, 16'h0004);
    step(1); expect_out("R4 NMI first at mask 7", 1, 32, 8);
    ack_it(); step(1); expect_out("R4/R3 next exception", 1, 35, 8);
    ack_it(); step(2); expect_out("R6 level 5 blocked by mask 7", 0, 0, 0);
    ack_it();
    cpu_mask = 4;
    step(1); expect_out("R11/R9 held request presented after mask drop", 1, 42, 5);
    ack_it();
  endtask

  task automatic t_mask_eq();
    cpu_mask = 5;
    pulse(0, 16'h0020);
    step(2); expect_out("R6 level equal to mask blocked", 0, 0, 0);
    cpu_mask = 4;
    step(1); expect_out("R6 level above mask accepted", 1, 45, 5);
    ack_it();
  endtask

  task automatic t_alias();
    cpu_mask = 0;
    pulse(0, 16'h0003);
    step(1); expect_out("R10 out-of-range write ignored", 1, 41, 2);
    ack_it(); step(1); expect_out("R10 source 0 keeps level 1", 1, 40, 1);
    ack_it();
  endtask

  task automatic t_simple();
    ictl_mode = 2'b01; cpu_mask = 7; glb_en = 0;
    pulse(0, 16'h0001);
    step(2); expect_out("R7 global enable off blocks", 0, 0, 0);
    pulse(8'h02, 0);
    step(1); expect_out("R4 exception ignores enable", 1, 33, 8);
    ack_it(); step(1); expect_out("R7 still blocked", 0, 0, 0);
    glb_en = 1;
    step(1); expect_out("R7 mask ignored in simple mode", 1, 40, 1);
    ack_it();
  endtask

  task automatic t_hold();
    ictl_mode = 2'b00; glb_en = 1;
    pulse(0, 16'h0080);
    step(1); expect_out("R8 presented", 1, 47, 3);
    pulse(8'h01, 0);
    step(2); expect_out("R8 held against NMI", 1, 47, 3);
    ack_it(); step(1); expect_out("R8 NMI after ack", 1, 32, 8);
    ack_it();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    step(3);
    rst_n = 1;
    t_reset();
    t_setup();
    t_basic();
    t_tie();
    t_exc();
    t_mask_eq();
    t_alias();
    t_simple();
    t_hold();
    step(2);
    finish_run();
  end
endmodule